// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block sits beside an 8-bit microcontroller core. It owns the timing base, the low-power modes and the qualified internal reset. The oscillator clock is split into two phases. Two phases form one state, and six states form one machine cycle, so one machine cycle is 12 oscillator clocks. The block publishes the current state index and phase so that the core can sequence itself. It also drives two clock enables, one for the processor and one for the peripherals. Both are asserted once per state, during phase 2, so every consumer runs at half the input rate and does not depend on the input duty cycle.

The power-control register is held here. One bit requests idle and one bit requests power-down. In idle the processor enable stops while the peripheral enable keeps running. Any enabled interrupt request ends idle. In power-down the oscillator-enable output drops, the timing base freezes and both enables stop. Only the reset pin ends power-down: a high level on the pin turns the oscillator back on, and the normal reset qualification then clears the mode.

The external reset pin is active high. It is synchronised and then sampled once per machine cycle, in the second phase of the fifth state. The internal reset asserts only after two consecutive high samples and is released at the end of a machine cycle. While reset is active, the power-control register clears every bit except bit 4. The reset values for the port latches and the stack pointer are published for the neighbouring registers.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: `stateIdx` (0..5 for states 1..6) and `phaseHi` (1 = phase 2) advance on every oscillator clock while `oscEn` is high: `phaseHi` toggles, and `stateIdx` steps after each phase 2, wrapping from 5 to 0. `cpuClkEn` and `perClkEn` are high only in cycles where `phaseHi` is 1.
- R2: `rstPin` passes a 2-flop synchroniser and is sampled only at `stateIdx`=4 with `phaseHi`=1. `rstOut` rises at the clock edge that ends the second consecutive sample that sees it high.
- R3: A high pulse on `rstPin` that covers fewer than two consecutive samples (for example 10 clocks) leaves `rstOut` low.
- R4: After the first low sample, `rstOut` falls at the edge that ends `stateIdx`=5, `phaseHi`=1.
- R5: In `pconQ`, bit 0 is idle and bit 1 is power-down. A write through `pconWe` and `pconWdata` loads the register at the next edge. A write with both bits set stores power-down only, with bit 0 cleared.
- R6: While bit 0 of `pconQ` is set, `cpuClkEn` stays low and `perClkEn` keeps pulsing. Bit 0 clears at the edge where `irqReq & irqEn` is nonzero. A request whose enable bit is 0 has no effect.
- R7: While bit 1 of `pconQ` is set, `cpuClkEn` and `perClkEn` stay low. `oscEn` is low unless the synchronised pin is high, and `stateIdx` and `phaseHi` hold their values while `oscEn` is low. Interrupt requests do not clear bit 1.
- R8: `porN` low clears all state. In every edge while `rstOut` is high, `pconQ` loads its old bit 4 and zeros in all other bits, and writes are ignored. `portRstVal` is FFh and `spRstVal` is 07h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstPin | input | 1 | External reset pin, active high |
| irqReq | input | 6 | Interrupt request lines |
| irqEn | input | 6 | Per-line interrupt enables |
| pconWe | input | 1 | Power-control register write strobe |
| pconWdata | input | 8 | Power-control write data |
| pconQ | output | 8 | Power-control register value |
| cpuClkEn | output | 1 | Processor clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| rstOut | output | 1 | Qualified internal reset |
| stateIdx | output | 3 | Current state within the machine cycle |
| phaseHi | output | 1 | High in phase 2 of a state |
| portRstVal | output | 8 | Reset value for port latches |
| spRstVal | output | 8 | Reset value for the stack pointer |

## Verification
A register write is visible on `pconQ` one edge later. An idle exit follows one edge after an enabled request. The oscillator enable follows the pin two edges later through the synchroniser. The internal reset moves only at the sample or boundary edge of a machine cycle, so it can trail the pin by up to two machine cycles plus the synchroniser. A cycle-level bench model advances on the same edge as the design and is compared with every output on the falling edge, which keeps each result in the cycle where it is due. Directed checks also confirm that the reset edges fall on the required state and phase, that short pin pulses are rejected, and that the enables stop in each mode.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  localparam logic [7:0] PORT_RST_VAL = 8'hFF;
  localparam logic [7:0] SP_RST_VAL   = 8'h07;

  // control -> datapath
  typedef struct packed {
    logic freeze;
  } ctrl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic rstInt;
    logic tick;
  } dp_status_t;
endpackage

// File: rtl/pwr_rst_dp.sv
module pwr_rst_dp
  import pwr_rst_pkg::*;
#(
  parameter int STATES       = 6,
  parameter int SAMPLE_STATE = 4,
  parameter int REQ_CYCLES   = 2,
  parameter int SYNC_STAGES  = 2,
  localparam int PHASES = STATES * 2,
  localparam int CW     = $clog2(PHASES),
  localparam int HW     = $clog2(REQ_CYCLES + 1)
) (
  input  logic         oscClk,
  input  logic         porN,
  input  logic         rstPin,
  input  ctrl_strobe_t strobe,
  output dp_status_t   status,
  output logic         oscEn,
  output logic [CW-2:0] stateIdx,
  output logic         phaseHi
);
  localparam logic [CW-1:0] LAST_CNT   = CW'(PHASES - 1);
  localparam logic [CW-1:0] SAMPLE_CNT = CW'(SAMPLE_STATE * 2 + 1);
  localparam logic [HW-1:0] REQ_HW     = HW'(REQ_CYCLES);
  localparam logic [HW-1:0] REQ_M1     = HW'(REQ_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hiCnt;
  logic rstQ;
  logic pinSync;
  logic run;

  // synchroniser chain, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge oscClk or negedge porN)
        if (!porN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= rstPin;
    end else begin : g_next
      always_ff @(posedge oscClk or negedge porN)
        if (!porN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign pinSync = syncQ[SYNC_STAGES-1];
  assign run     = !strobe.freeze || pinSync;

  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      cnt   <= '0;
      hiCnt <= '0;
      rstQ  <= 1'b0;
    end else if (run) begin
      cnt <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
      if (cnt == SAMPLE_CNT) begin
        if (pinSync) begin
          if (hiCnt != REQ_HW) hiCnt <= hiCnt + 1'b1;
          if (hiCnt >= REQ_M1) rstQ <= 1'b1;
        end else begin
          hiCnt <= '0;
        end
      end
      if (cnt == LAST_CNT && rstQ && hiCnt == '0) rstQ <= 1'b0;
    end
  end

  assign oscEn         = run;
  assign stateIdx      = cnt[CW-1:1];
  assign phaseHi       = cnt[0];
  assign status.rstInt = rstQ;
  assign status.tick   = run && cnt[0];
endmodule

// File: rtl/pwr_rst_mode.sv
module pwr_rst_mode
  import pwr_rst_pkg::*;
#(
  parameter int IRQ_W    = 6,
  parameter int PCON_W   = 8,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1,
  parameter logic [PCON_W-1:0] KEEP_MASK = 8'h10
) (
  input  logic              oscClk,
  input  logic              porN,
  input  logic [IRQ_W-1:0]  irqReq,
  input  logic [IRQ_W-1:0]  irqEn,
  input  logic              pconWe,
  input  logic [PCON_W-1:0] pconWdata,
  input  dp_status_t        status,
  output ctrl_strobe_t      strobe,
  output logic [PCON_W-1:0] pconQ,
  output logic              cpuClkEn,
  output logic              perClkEn
);
  logic [PCON_W-1:0] pconNxt;
  logic wake;

  assign wake = |(irqReq & irqEn);

  always_comb begin
    pconNxt = pconQ;
    if (pconWe) pconNxt = pconWdata;
    if (pconNxt[PD_BIT]) pconNxt[IDLE_BIT] = 1'b0;
    if (wake) pconNxt[IDLE_BIT] = 1'b0;
  end

  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN)              pconQ <= '0;
    else if (status.rstInt) pconQ <= pconQ & KEEP_MASK;
    else                    pconQ <= pconNxt;
  end

  assign strobe.freeze = pconQ[PD_BIT];
  assign cpuClkEn = status.tick && !pconQ[IDLE_BIT] && !pconQ[PD_BIT];
  assign perClkEn = status.tick && !pconQ[PD_BIT];
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import pwr_rst_pkg::*;
#(
  parameter int IRQ_W        = 6,
  parameter int STATES       = 6,
  parameter int SAMPLE_STATE = 4,
  parameter int REQ_CYCLES   = 2,
  parameter int SYNC_STAGES  = 2,
  localparam int SW = $clog2(STATES * 2) - 1
) (
  input  logic             oscClk,
  input  logic             porN,
  input  logic             rstPin,
  input  logic [IRQ_W-1:0] irqReq,
  input  logic [IRQ_W-1:0] irqEn,
  input  logic             pconWe,
  input  logic [7:0]       pconWdata,
  output logic [7:0]       pconQ,
  output logic             cpuClkEn,
  output logic             perClkEn,
  output logic             oscEn,
  output logic             rstOut,
  output logic [SW-1:0]    stateIdx,
  output logic             phaseHi,
  output logic [7:0]       portRstVal,
  output logic [7:0]       spRstVal
);
  ctrl_strobe_t strobe;
  dp_status_t   status;

  pwr_rst_dp #(
    .STATES(STATES), .SAMPLE_STATE(SAMPLE_STATE),
    .REQ_CYCLES(REQ_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .oscClk(oscClk), .porN(porN), .rstPin(rstPin), .strobe(strobe),
    .status(status), .oscEn(oscEn), .stateIdx(stateIdx), .phaseHi(phaseHi)
  );

  pwr_rst_mode #(.IRQ_W(IRQ_W)) mode_i (
    .oscClk(oscClk), .porN(porN), .irqReq(irqReq), .irqEn(irqEn),
    .pconWe(pconWe), .pconWdata(pconWdata), .status(status),
    .strobe(strobe), .pconQ(pconQ), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn)
  );

  assign rstOut     = status.rstInt;
  assign portRstVal = PORT_RST_VAL;
  assign spRstVal   = SP_RST_VAL;
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
module pwr_rst_ctrl_chk (
  input logic       oscClk,
  input logic       porN,
  input logic [7:0] pconQ,
  input logic       cpuClkEn,
  input logic       perClkEn,
  input logic       oscEn,
  input logic       rstOut,
  input logic [2:0] stateIdx,
  input logic       phaseHi
);
  a_r1_tick_phase: assert property (@(posedge oscClk) disable iff (!porN)
    (cpuClkEn || perClkEn) |-> phaseHi);
  a_r1_state_step: assert property (@(posedge oscClk) disable iff (!porN)
    (oscEn && phaseHi && stateIdx != 3'd5) |=> stateIdx == $past(stateIdx) + 3'd1);
  a_r1_state_wrap: assert property (@(posedge oscClk) disable iff (!porN)
    (oscEn && phaseHi && stateIdx == 3'd5) |=> stateIdx == 3'd0);
  a_r2_rise_at_sample: assert property (@(posedge oscClk) disable iff (!porN)
    $rose(rstOut) |-> ($past(stateIdx) == 3'd4 && $past(phaseHi)));
  a_r4_fall_at_boundary: assert property (@(posedge oscClk) disable iff (!porN)
    $fell(rstOut) |-> ($past(stateIdx) == 3'd5 && $past(phaseHi)));
  a_r6_idle_cpu_off: assert property (@(posedge oscClk) disable iff (!porN)
    pconQ[0] |-> !cpuClkEn);
  a_r7_pd_enables_off: assert property (@(posedge oscClk) disable iff (!porN)
    pconQ[1] |-> (!cpuClkEn && !perClkEn));
  a_r7_frozen: assert property (@(posedge oscClk) disable iff (!porN)
    !oscEn |=> ($stable(stateIdx) && $stable(phaseHi)));
  a_r8_clear: assert property (@(posedge oscClk) disable iff (!porN)
    rstOut |=> ((pconQ & 8'hEF) == 8'h00));
  a_r8_keep_bit4: assert property (@(posedge oscClk) disable iff (!porN)
    rstOut |=> pconQ[4] == $past(pconQ[4]));
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk chk_i (
  .oscClk(oscClk), .porN(porN), .pconQ(pconQ), .cpuClkEn(cpuClkEn),
  .perClkEn(perClkEn), .oscEn(oscEn), .rstOut(rstOut),
  .stateIdx(stateIdx), .phaseHi(phaseHi)
);

// File: tb/pwr_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_rst_ctrl_tb_top;
  logic oscClk = 1'b0;
  logic porN = 1'b0;
  logic rstPin = 1'b0;
  logic [5:0] irqReq = '0;
  logic [5:0] irqEn = '0;
  logic pconWe = 1'b0;
  logic [7:0] pconWdata = '0;
  logic [7:0] pconQ, portRstVal, spRstVal;
  logic cpuClkEn, perClkEn, oscEn, rstOut, phaseHi;
  logic [2:0] stateIdx;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int rises = 0;
  int falls = 0;
  logic modelOn = 1'b0;

  always #4 oscClk = ~oscClk;

  pwr_rst_ctrl dut_i (
    .oscClk(oscClk), .porN(porN), .rstPin(rstPin), .irqReq(irqReq), .irqEn(irqEn),
    .pconWe(pconWe), .pconWdata(pconWdata), .pconQ(pconQ), .cpuClkEn(cpuClkEn),
    .perClkEn(perClkEn), .oscEn(oscEn), .rstOut(rstOut), .stateIdx(stateIdx),
    .phaseHi(phaseHi), .portRstVal(portRstVal), .spRstVal(spRstVal)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // bench reference model built from the requirements
  logic m_s1, m_s2, m_rst;
  int m_cnt, m_hi;
  logic [7:0] m_pcon;

  function automatic logic m_run();
    return !m_pcon[1] || m_s2;
  endfunction

  always @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      m_s1 <= 0; m_s2 <= 0; m_rst <= 0; m_cnt <= 0; m_hi <= 0; m_pcon <= 0;
    end else begin
      logic [7:0] np;
      m_s1 <= rstPin;
      m_s2 <= m_s1;
      if (m_run()) begin
        m_cnt <= (m_cnt + 1) % 12;
        if (m_cnt == 9) begin
          if (m_s2) begin
            m_hi <= (m_hi < 2) ? m_hi + 1 : 2;
            if (m_hi >= 1) m_rst <= 1;
          end else m_hi <= 0;
        end
        if (m_cnt == 11 && m_rst && m_hi == 0) m_rst <= 0;
      end
      np = pconWe ? pconWdata : m_pcon;
      if (np[1]) np[0] = 0;
      if ((irqReq & irqEn) != 0) np[0] = 0;
      m_pcon <= m_rst ? (m_pcon & 8'h10) : np;
    end
  end

  logic prevRst = 0;
  logic [2:0] prevState = 0;
  logic prevPh = 0;
  always @(negedge oscClk) begin
    if (modelOn) begin
      logic expOsc, expPh;
      expOsc = m_run();
      expPh = m_cnt[0];
      check("R1 stateIdx", {5'd0, stateIdx}, 8'(m_cnt / 2));
      check("R1 phaseHi", {7'd0, phaseHi}, {7'd0, expPh});
      check("R6 cpuClkEn", {7'd0, cpuClkEn}, {7'd0, expOsc & expPh & !m_pcon[0] & !m_pcon[1]});
      check("R7 perClkEn", {7'd0, perClkEn}, {7'd0, expOsc & expPh & !m_pcon[1]});
      check("R7 oscEn", {7'd0, oscEn}, {7'd0, expOsc});
      check("R2 rstOut", {7'd0, rstOut}, {7'd0, m_rst});
      check("R5 pconQ", pconQ, m_pcon);
      if (rstOut && !prevRst) begin
        rises++;
        check("R2 rise state", {4'd0, prevState, prevPh}, {4'd0, 3'd4, 1'b1});
      end
      if (!rstOut && prevRst) begin
        falls++;
        check("R4 fall state", {4'd0, prevState, prevPh}, {4'd0, 3'd5, 1'b1});
      end
    end
    prevRst = rstOut; prevState = stateIdx; prevPh = phaseHi;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge oscClk);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    pconWe = 1; pconWdata = d;
    cyc(1);
    pconWe = 0;
  endtask

  task automatic pinPulse(int n);
    rstPin = 1; cyc(n); rstPin = 0;
  endtask

  always @(posedge oscClk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r0, cpuSeen, perSeen;
    logic [2:0] held;
    void'($urandom(32'h5eed1234));
    cyc(3);
    check("R8 por pconQ", pconQ, 8'h00);
    check("R8 por rstOut", {7'd0, rstOut}, 8'h00);
    check("R8 portRstVal", portRstVal, 8'hFF);
    check("R8 spRstVal", spRstVal, 8'h07);
    porN = 1; modelOn = 1;
    cyc(30);

    // R3: short pulse rejected
    r0 = rises;
    pinPulse(10); cyc(40);
    check("R3 glitch ignored", 8'(rises - r0), 8'd0);

    // R2 / R4 / R8: qualified reset keeps bit 4
    wr(8'h5C);
    check("R5 write", pconQ, 8'h5C);
    r0 = rises;
    pinPulse(40);
    wr(8'hE0);
    check("R8 write ignored in reset", pconQ, 8'h10);
    cyc(40);
    check("R2 reset taken", 8'(rises - r0), 8'd1);
    check("R8 keep bit4", pconQ, 8'h10);

    // R6: idle
    wr(8'h01);
    cpuSeen = 0; perSeen = 0;
    for (int i = 0; i < 24; i++) begin
      cpuSeen += int'(cpuClkEn); perSeen += int'(perClkEn); cyc(1);
    end
    check("R6 cpu stopped", 8'(cpuSeen), 8'd0);
    check("R6 periph runs", 8'(perSeen), 8'd12);
    irqReq = 6'h04; irqEn = 6'h3B; cyc(1); irqReq = 0;
    check("R6 disabled irq", pconQ, 8'h01);
    irqReq = 6'h08; cyc(1); irqReq = 0;
    check("R6 enabled irq exit", pconQ, 8'h00);

    // R5 / R7: power-down
    wr(8'h03);
    check("R5 pd wins", pconQ, 8'h02);
    check("R7 osc off", {7'd0, oscEn}, 8'h00);
    held = stateIdx;
    irqReq = 6'h08; cyc(20); irqReq = 0;
    check("R7 frozen", {5'd0, stateIdx}, {5'd0, held});
    check("R7 irq no exit", pconQ, 8'h02);
    rstPin = 1; cyc(2);
    check("R7 osc wake", {7'd0, oscEn}, 8'h01);
    cyc(40); rstPin = 0; cyc(40);
    check("R7 pd cleared by reset", pconQ, 8'h00);

    // random mix
    irqEn = 6'h3F;
    for (int k = 0; k < 60; k++) begin
      case ($urandom % 5)
        0: wr(8'($urandom) & 8'hFD);
        1: wr(8'h02);
        2: begin irqReq = 6'($urandom); cyc(1); irqReq = 0; end
        3: pinPulse(1 + $urandom % 40);
        default: cyc(1 + $urandom % 30);
      endcase
    end
    pinPulse(40); cyc(40);
    check("R4 released", {7'd0, rstOut}, 8'h00);
    check("R4 falls seen", 8'(falls > 0), 8'd1);
    modelOn = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule